// File: doc/BRIEF.md
# Status-Polled Flash Bank Sequencer

This block runs the erase and program sequences of one bank of a byte-wide flash device. The device takes command bytes and reports progress through a status byte. An erase request sends the two-byte erase command to the bank base. It then polls the status byte until the device reports completion, or until a poll budget runs out. A program request walks the whole bank. For each byte it fetches the source value from a local image buffer, writes the program setup command to that byte's address, waits a minimum setup gap, writes the data byte, and polls for completion.

Every operation ends the same way, whether it finished or was cut short. The block writes the clear-status command and then the read-mode command, so the device is back in read mode. It then reads the bank back and compares it with the expected content: all 0xFF after an erase, or the image after a program. The result is reported as a one-cycle `done` pulse and a two-bit error code. The code stays valid until the next accepted request.

States: `ST_IDLE`, `ST_ERS_SETUP`, `ST_ERS_CONFIRM`, `ST_PGM_FETCH`, `ST_PGM_SETUP`, `ST_PGM_GAP`, `ST_PGM_DATA`, `ST_POLL_CMD`, `ST_POLL_READ`, `ST_POLL_EVAL`, `ST_CLR_STAT`, `ST_RST_READ`, `ST_VFY_READ`, `ST_VFY_CHECK`, `ST_DONE`.

Transitions:
- From `ST_IDLE`:
  - an erase request goes to `ST_ERS_SETUP`, then `ST_ERS_CONFIRM`, then `ST_POLL_CMD`;
  - a program request goes to `ST_PGM_FETCH`.
- Program byte path: `ST_PGM_FETCH` → `ST_PGM_SETUP` → `ST_PGM_GAP`. The block stays in `ST_PGM_GAP` until the gap count expires, then goes `ST_PGM_DATA` → `ST_POLL_CMD`.
- Poll loop: `ST_POLL_CMD` → `ST_POLL_READ` → `ST_POLL_EVAL`. From `ST_POLL_EVAL`:
  - a not-ready status goes back to `ST_POLL_CMD`, or to `ST_CLR_STAT` on timeout;
  - a ready status goes to `ST_CLR_STAT` on a fault, on an erase, or on the last program byte;
  - otherwise it advances to the next byte in `ST_PGM_FETCH`.
- Ending: `ST_CLR_STAT` → `ST_RST_READ` → `ST_VFY_READ` → `ST_VFY_CHECK`. From `ST_VFY_CHECK` the block loops to `ST_VFY_READ`, or goes to `ST_DONE` on a mismatch or after the last byte. `ST_DONE` → `ST_IDLE`.

Top module: `flash_bank_seq`

## Requirements
- R1: An erase writes command 0x20 and then, in the next cycle, 0xD0, both to bank address 0. Every command write (0x20, 0xD0, 0x70, 0x50, 0xFF) goes to address 0.
- R2: Polling writes 0x70 to address 0 and, in the following cycle, reads the status byte. Bit 7 = 1 means ready. A ready status with any of bits 5:3 set ends the operation with error code 1, and no further byte is programmed.
- R3: Each program byte is preceded by a 0x40 write to that byte's own address. The data write to the same address comes at least GAP_CYC cycles later, where GAP_CYC = ceil(CLK_MHZ*SETUP_NS/1000), with a minimum of 1.
- R4: POLL_LIMIT consecutive status reads with bit 7 = 0 end the operation with error code 2. In a program, no further byte is written.
- R5: Every operation, including a failed one, writes 0x50 and then, in the next cycle, 0xFF, both to address 0, before any readback.
- R6: After R5 the bank is read from address 0 upward. The expected value is 0xFF after an erase and the image byte after a program. The first mismatch stops the readback and sets error code 3, unless an earlier error is already recorded. Erase verify runs even after a timeout.
- R7: `busy` rises in the cycle after an accepted request and falls in the cycle after `done`. `done` is a one-cycle pulse. `err_code` (0 none, 1 status fault, 2 timeout, 3 verify mismatch) holds from `done` until the next accepted request.
- R8: Requests that arrive while `busy` is high are ignored. If erase and program are requested in the same cycle, the erase is taken.
- R9: After reset, `busy`, `done` and `err_code` are 0. There is no bus activity while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_erase | input | 1 | Erase request, sampled while idle |
| start_prog | input | 1 | Program request, sampled while idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result: 0 ok, 1 status fault, 2 timeout, 3 verify mismatch |
| img_rd | output | 1 | Image buffer read strobe; data is expected one cycle later |
| img_addr | output | AW | Image buffer byte address |
| img_data | input | 8 | Image buffer read data |
| fl_wr | output | 1 | Flash byte write strobe |
| fl_rd | output | 1 | Flash byte read strobe; data is expected one cycle later |
| fl_addr | output | AW | Flash byte address within the bank |
| fl_wdata | output | 8 | Flash write data or command |
| fl_rdata | input | 8 | Flash read data |

## Verification
The hardest situations to reach are the aborted ones. Examples are a program loop that ends after its first byte because of a status fault or a timeout, and a readback that stops part way through the bank. These can only be reached through the device's answers. The bench flash model therefore has knobs that the stimulus sets per operation: a stuck-busy switch, injected status fault bits, and a weak cell with a bit that cannot be set. These knobs are mixed with seeded random device latencies and random images. The model also counts data writes, status reads and array reads, so the bench can see at the ports where an abort cut the sequence short.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam logic [7:0] CMD_ERS_SETUP   = 8'h20;
    localparam logic [7:0] CMD_ERS_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_PGM_SETUP   = 8'h40;
    localparam logic [7:0] CMD_READ_STAT   = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT    = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

    localparam logic [7:0] STAT_READY_MASK = 8'h80;
    localparam logic [7:0] STAT_FAULT_MASK = 8'h38;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_STATUS  = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_VERIFY  = 2'd3
    } fbs_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ERS_SETUP,
        ST_ERS_CONFIRM,
        ST_PGM_FETCH,
        ST_PGM_SETUP,
        ST_PGM_GAP,
        ST_PGM_DATA,
        ST_POLL_CMD,
        ST_POLL_READ,
        ST_POLL_EVAL,
        ST_CLR_STAT,
        ST_RST_READ,
        ST_VFY_READ,
        ST_VFY_CHECK,
        ST_DONE
    } fbs_state_e;

endpackage

// File: rtl/fbs_tally.sv
// Clearable event counter that flags the last of LIMIT counted events.
module fbs_tally #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && (q != W'(LIMIT))) begin
            q <= q + 1'b1;
        end
    end

    assign last = (q == W'(LIMIT - 1));

endmodule

// File: rtl/fbs_status_eval.sv
// Decodes a device status byte into ready and fault flags.
module fbs_status_eval
    import fbs_pkg::*;
(
    input  logic [7:0] status,
    output logic       ready,
    output logic       fault
);
    always_comb begin
        ready = |(status & STAT_READY_MASK);
        fault = ready && (|(status & STAT_FAULT_MASK));
    end
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
    import fbs_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 8192,
    parameter int unsigned CLK_MHZ    = 100,
    parameter int unsigned SETUP_NS   = 1000,
    parameter int unsigned POLL_LIMIT = 1000000,
    localparam int unsigned AW        = $clog2(BANK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_erase,
    input  logic          start_prog,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err_code,
    output logic          img_rd,
    output logic [AW-1:0] img_addr,
    input  logic [7:0]    img_data,
    output logic          fl_wr,
    output logic          fl_rd,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    input  logic [7:0]    fl_rdata
);
    localparam int unsigned GAP_RAW = (CLK_MHZ * SETUP_NS + 999) / 1000;
    localparam int unsigned GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam logic [AW-1:0] LAST_IDX = AW'(BANK_BYTES - 1);

    fbs_state_e    state, state_nx;
    logic          op_prog_q;
    logic [AW-1:0] idx_q;
    logic [7:0]    byte_q;
    fbs_err_e      err_q;

    logic gap_clr, gap_inc, gap_last;
    logic poll_clr, poll_inc, poll_last;
    logic st_ready, st_fault;
    logic idx_last;
    logic vfy_match;
    logic [7:0] vfy_expect;

    assign idx_last   = (idx_q == LAST_IDX);
    assign vfy_expect = op_prog_q ? img_data : 8'hFF;
    assign vfy_match  = (fl_rdata == vfy_expect);

    // Setup-to-data gap counter.
    fbs_tally #(.LIMIT(GAP_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gap_clr),
        .inc   (gap_inc),
        .last  (gap_last)
    );

    // Consecutive not-ready poll counter.
    fbs_tally #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    fbs_status_eval u_stat (
        .status (fl_rdata),
        .ready  (st_ready),
        .fault  (st_fault)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_erase)     state_nx = ST_ERS_SETUP;
                else if (start_prog) state_nx = ST_PGM_FETCH;
            end
            ST_ERS_SETUP:   state_nx = ST_ERS_CONFIRM;
            ST_ERS_CONFIRM: state_nx = ST_POLL_CMD;
            ST_PGM_FETCH:   state_nx = ST_PGM_SETUP;
            ST_PGM_SETUP:   state_nx = ST_PGM_GAP;
            ST_PGM_GAP:     if (gap_last) state_nx = ST_PGM_DATA;
            ST_PGM_DATA:    state_nx = ST_POLL_CMD;
            ST_POLL_CMD:    state_nx = ST_POLL_READ;
            ST_POLL_READ:   state_nx = ST_POLL_EVAL;
            ST_POLL_EVAL: begin
                if (!st_ready) begin
                    state_nx = poll_last ? ST_CLR_STAT : ST_POLL_CMD;
                end else if (st_fault || !op_prog_q || idx_last) begin
                    state_nx = ST_CLR_STAT;
                end else begin
                    state_nx = ST_PGM_FETCH;
                end
            end
            ST_CLR_STAT:    state_nx = ST_RST_READ;
            ST_RST_READ:    state_nx = ST_VFY_READ;
            ST_VFY_READ:    state_nx = ST_VFY_CHECK;
            ST_VFY_CHECK: begin
                if (!vfy_match || idx_last) state_nx = ST_DONE;
                else                        state_nx = ST_VFY_READ;
            end
            ST_DONE:        state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_prog_q <= 1'b0;
            idx_q     <= '0;
            byte_q    <= 8'h00;
            err_q     <= ERR_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_erase || start_prog) begin
                        op_prog_q <= !start_erase;
                        idx_q     <= '0;
                        err_q     <= ERR_NONE;
                    end
                end
                ST_PGM_SETUP: byte_q <= img_data;
                ST_POLL_EVAL: begin
                    if (!st_ready) begin
                        if (poll_last) err_q <= ERR_TIMEOUT;
                    end else if (st_fault) begin
                        err_q <= ERR_STATUS;
                    end else if (op_prog_q && !idx_last) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_RST_READ: idx_q <= '0;
                ST_VFY_CHECK: begin
                    if (!vfy_match) begin
                        if (err_q == ERR_NONE) err_q <= ERR_VERIFY;
                    end else if (!idx_last) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        fl_addr  = '0;
        fl_wdata = 8'h00;
        img_rd   = 1'b0;
        img_addr = idx_q;
        gap_clr  = 1'b0;
        gap_inc  = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        busy     = (state != ST_IDLE);
        done     = 1'b0;
        err_code = err_q;
        unique case (state)
            ST_IDLE: ;
            ST_ERS_SETUP: begin
                fl_wr    = 1'b1;
                fl_wdata = CMD_ERS_SETUP;
            end
            ST_ERS_CONFIRM: begin
                fl_wr    = 1'b1;
                fl_wdata = CMD_ERS_CONFIRM;
                poll_clr = 1'b1;
            end
            ST_PGM_FETCH: img_rd = 1'b1;
            ST_PGM_SETUP: begin
                fl_wr    = 1'b1;
                fl_addr  = idx_q;
                fl_wdata = CMD_PGM_SETUP;
                gap_clr  = 1'b1;
            end
            ST_PGM_GAP: gap_inc = 1'b1;
            ST_PGM_DATA: begin
                fl_wr    = 1'b1;
                fl_addr  = idx_q;
                fl_wdata = byte_q;
                poll_clr = 1'b1;
            end
            ST_POLL_CMD: begin
                fl_wr    = 1'b1;
                fl_wdata = CMD_READ_STAT;
            end
            ST_POLL_READ: fl_rd = 1'b1;
            ST_POLL_EVAL: poll_inc = !st_ready;
            ST_CLR_STAT: begin
                fl_wr    = 1'b1;
                fl_wdata = CMD_CLR_STAT;
            end
            ST_RST_READ: begin
                fl_wr    = 1'b1;
                fl_wdata = CMD_READ_ARRAY;
            end
            ST_VFY_READ: begin
                fl_rd   = 1'b1;
                fl_addr = idx_q;
                img_rd  = op_prog_q;
            end
            ST_VFY_CHECK: ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // Checker-side count of cycles since the last program setup write.
    localparam int unsigned GW = $clog2(GAP_CYC + 2);
    logic [GW-1:0] gap_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_seen <= '0;
        end else if (fl_wr && fl_wdata == CMD_PGM_SETUP && state == ST_PGM_SETUP) begin
            gap_seen <= '0;
        end else if (gap_seen != GW'(GAP_CYC + 1)) begin
            gap_seen <= gap_seen + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_wr && !fl_rd && !done)); // R9
    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd)); // R9
    AST_CONFIRM_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && fl_wdata == CMD_ERS_CONFIRM && state == ST_ERS_CONFIRM)
        |-> ($past(fl_wr) && $past(fl_wdata) == CMD_ERS_SETUP && fl_addr == '0)); // R1
    AST_READ_AFTER_STATCMD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_READ) |-> (fl_rd && $past(fl_wr) && $past(fl_wdata) == CMD_READ_STAT)); // R2
    AST_GAP_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_DATA) |-> (gap_seen >= GW'(GAP_CYC))); // R3
    AST_RESET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && fl_wdata == CMD_READ_ARRAY && state == ST_RST_READ)
        |-> ($past(fl_wr) && $past(fl_wdata) == CMD_CLR_STAT && fl_addr == '0)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_erase && !start_prog) |=> $stable(err_code)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && (start_erase || start_prog)) |=> (busy && $stable(op_prog_q))); // R8

endmodule

// File: tb/test_flash_bank_seq.sv
module test_flash_bank_seq;
    // Bank, clock-rate and poll budget are shrunk to keep the run short.
    localparam int unsigned BANK    = 32;
    localparam int unsigned CLKMHZ  = 8;
    localparam int unsigned SETNS   = 1000;
    localparam int unsigned PLIM    = 20;
    localparam int unsigned AW      = $clog2(BANK);
    localparam int unsigned GAP_EXP = (CLKMHZ * SETNS + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_erase = 1'b0, start_prog = 1'b0;
    logic busy, done;
    logic [1:0] err_code;
    logic img_rd, fl_wr, fl_rd;
    logic [AW-1:0] img_addr, fl_addr;
    logic [7:0] img_data, fl_wdata, fl_rdata;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    flash_bank_seq #(
        .BANK_BYTES(BANK), .CLK_MHZ(CLKMHZ), .SETUP_NS(SETNS), .POLL_LIMIT(PLIM)
    ) i_flash_bank_seq (
        .clk(clk), .rst_n(rst_n), .start_erase(start_erase), .start_prog(start_prog),
        .busy(busy), .done(done), .err_code(err_code),
        .img_rd(img_rd), .img_addr(img_addr), .img_data(img_data),
        .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    // Image buffer.
    logic [7:0] img [BANK];
    always @(posedge clk) if (img_rd) img_data <= img[img_addr];

    // Flash device model with fault knobs.
    logic [7:0] mem [BANK];
    logic stat_mode = 0, prog_armed = 0, ers_armed = 0;
    int busy_cnt = 0, lat = 0, cyc = 0, setup_cyc = 0;
    logic [AW-1:0] setup_addr = '0;
    logic stuck = 0, weak_en = 0, log_clr = 0;
    int weak_idx = 0;
    logic [7:0] inj_err = 8'h00, err_bits = 8'h00, prev_w = 8'h00;
    logic [7:0] first_w0 = 8'h00, first_w1 = 8'h00;
    int n_writes = 0, n_ers_setup = 0, n_pgm_setup = 0, n_data = 0, n_stat_reads = 0;
    int n_arr_reads = 0, n_clr_rst = 0, n_addr_bad = 0, n_gap_bad = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (log_clr) begin
            n_writes <= 0; n_ers_setup <= 0; n_pgm_setup <= 0; n_data <= 0;
            n_stat_reads <= 0; n_arr_reads <= 0; n_clr_rst <= 0; n_addr_bad <= 0;
            n_gap_bad <= 0;
        end else begin
            if (fl_wr) begin
                n_writes <= n_writes + 1;
                if (n_writes == 0) first_w0 <= fl_wdata;
                if (n_writes == 1) first_w1 <= fl_wdata;
                prev_w <= fl_wdata;
                if (prog_armed) begin
                    prog_armed <= 1'b0;
                    n_data <= n_data + 1;
                    if (fl_addr != setup_addr) n_addr_bad <= n_addr_bad + 1;
                    if (cyc - setup_cyc < int'(GAP_EXP)) n_gap_bad <= n_gap_bad + 1;
                    mem[fl_addr] <= mem[fl_addr] & fl_wdata &
                        ((weak_en && int'(fl_addr) == weak_idx) ? 8'hFE : 8'hFF);
                    busy_cnt <= lat;
                    err_bits <= inj_err;
                end else begin
                    if (fl_wdata != 8'h40 && fl_addr != '0) n_addr_bad <= n_addr_bad + 1;
                    ers_armed <= 1'b0;
                    case (fl_wdata)
                        8'h40: begin
                            prog_armed <= 1'b1; setup_cyc <= cyc; setup_addr <= fl_addr;
                            n_pgm_setup <= n_pgm_setup + 1;
                        end
                        8'h20: begin ers_armed <= 1'b1; n_ers_setup <= n_ers_setup + 1; end
                        8'hD0: if (ers_armed) begin
                            for (int k = 0; k < int'(BANK); k++)
                                mem[k] <= (weak_en && k == weak_idx) ? 8'hFE : 8'hFF;
                            busy_cnt <= lat;
                            err_bits <= inj_err;
                        end
                        8'h70: stat_mode <= 1'b1;
                        8'h50: err_bits <= 8'h00;
                        8'hFF: begin
                            stat_mode <= 1'b0;
                            if (prev_w == 8'h50) n_clr_rst <= n_clr_rst + 1;
                        end
                        default: ;
                    endcase
                end
            end
            if (fl_rd) begin
                if (stat_mode) begin
                    fl_rdata <= {!(stuck || busy_cnt != 0), 1'b0, err_bits[5:3], 3'b000};
                    n_stat_reads <= n_stat_reads + 1;
                end else begin
                    fl_rdata <= mem[fl_addr];
                    n_arr_reads <= n_arr_reads + 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Launch one operation and wait for its completion pulse.
    task automatic run_op(input logic er, input logic pg);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        start_erase = er; start_prog = pg;
        @(negedge clk); start_erase = 1'b0; start_prog = 1'b0;
        check("R7 busy after start", int'(busy), 1);
        for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
        check("R7 done seen", int'(done), 1);
        @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
        check("R7 busy cleared", int'(busy), 0);
    endtask

    function automatic int img_diffs();
        int d = 0;
        for (int k = 0; k < int'(BANK); k++) if (mem[k] != img[k]) d++;
        return d;
    endfunction

    function automatic int erased_diffs();
        int d = 0;
        for (int k = 0; k < int'(BANK); k++) if (mem[k] != 8'hFF) d++;
        return d;
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'd2024));
        for (int k = 0; k < int'(BANK); k++) begin mem[k] = 8'h00; img[k] = 8'h00; end
        repeat (3) @(negedge clk);
        check("R9 busy in reset", int'(busy), 0);
        check("R9 err in reset", int'(err_code), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 done idle", int'(done), 0);
        check("R9 no bus while idle", int'(fl_wr || fl_rd), 0);

        // Directed erase.
        lat = 3;
        run_op(1'b1, 1'b0);
        check("R1 first write 0x20", int'(first_w0), 32'h20);
        check("R1 second write 0xD0", int'(first_w1), 32'hD0);
        check("R1 command address 0", n_addr_bad, 0);
        check("R5 clear then reset", n_clr_rst, 1);
        check("R6 erase readback length", n_arr_reads, int'(BANK));
        check("R6 bank erased", erased_diffs(), 0);
        check("R7 err ok", int'(err_code), 0);

        // Random erase/program rounds.
        for (int r = 0; r < 4; r++) begin
            lat = int'($urandom_range(0, 12));
            run_op(1'b1, 1'b0);
            check("R6 erase ok", int'(err_code), 0);
            for (int k = 0; k < int'(BANK); k++) img[k] = 8'($urandom);
            if (r == 0) begin img[0] = 8'h00; img[BANK-1] = 8'hFF; end
            lat = int'($urandom_range(0, 12));
            run_op(1'b0, 1'b1);
            check("R3 setup count", n_pgm_setup, int'(BANK));
            check("R3 data count", n_data, int'(BANK));
            check("R3 gap and address", n_gap_bad + n_addr_bad, 0);
            check("R6 program image", img_diffs(), 0);
            check("R6 program readback length", n_arr_reads, int'(BANK));
            check("R7 err ok", int'(err_code), 0);
        end
        repeat (5) @(negedge clk);
        check("R7 err holds while idle", int'(err_code), 0);

        // Status fault during program.
        lat = 2;
        run_op(1'b1, 1'b0);
        inj_err = 8'h10;
        run_op(1'b0, 1'b1);
        check("R2 status fault code", int'(err_code), 1);
        check("R2 loop aborted", n_data, 1);
        check("R5 clear/reset after fault", n_clr_rst, 1);
        run_op(1'b1, 1'b0);
        check("R2 erase status fault", int'(err_code), 1);
        inj_err = 8'h00;

        // Timeout during program, then during erase.
        stuck = 1'b1;
        run_op(1'b0, 1'b1);
        check("R4 timeout code", int'(err_code), 2);
        check("R4 poll reads", n_stat_reads, int'(PLIM));
        check("R4 loop aborted", n_data, 1);
        check("R5 clear/reset after timeout", n_clr_rst, 1);
        run_op(1'b1, 1'b0);
        check("R4 erase timeout", int'(err_code), 2);
        check("R6 verify after timeout", n_arr_reads, int'(BANK));
        stuck = 1'b0;

        // Weak cell: verify mismatch stops readback.
        weak_en = 1'b1; weak_idx = 5; lat = 1;
        run_op(1'b1, 1'b0);
        check("R6 erase verify fail", int'(err_code), 3);
        check("R6 stop at first mismatch", n_arr_reads, 6);
        img[5] = 8'hA5;
        run_op(1'b0, 1'b1);
        check("R6 program verify fail", int'(err_code), 3);
        check("R6 program stop at mismatch", n_arr_reads, 6);
        weak_en = 1'b0;

        // Request while busy is ignored; simultaneous requests pick erase.
        lat = 4;
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0; start_erase = 1'b1;
        @(negedge clk); start_erase = 1'b0;
        repeat (3) @(negedge clk);
        start_prog = 1'b1;
        @(negedge clk); start_prog = 1'b0;
        for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R8 no program after busy request", n_pgm_setup, 0);
        check("R8 stays idle", int'(busy), 0);
        run_op(1'b1, 1'b1);
        check("R8 erase wins", n_ers_setup, 1);
        check("R8 no program setup", n_pgm_setup, 0);
        check("R8 err ok", int'(err_code), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule